// File: doc/BRIEF.md
# Frame-Triggered Burst Clock Generator

This block sits between a host serial receive port and an absolute-position sensor with a synchronous serial interface. The host supplies a free-running bit clock and a one-cycle frame-sync pulse. Each frame sync starts one burst of exactly 32 clock cycles on the sensor clock. Between bursts the sensor clock rests high. The sensor shifts out its 32-bit position, most significant bit first, and the block captures it. The host clock is never gated. The host therefore always sees a continuous 64-slot frame: the first 32 slots carry position data and the last 32 slots are padding.

All logic runs on the supplied bit clock and holds no time constant of its own. Any bit clock rate the sensor accepts can be used, such as 100 kHz to 800 kHz. A completed word is held in a register and shifted out to the host in slots 0 to 31 of the following frame. This makes every slot line up with the host frame sync, at the cost of one frame of latency. Data moves at a fixed rate set by the bit clock, with no valid/ready handshake. The host cannot apply back-pressure: a host that misses a slot loses that bit. A frame-error level tells the host when its frame syncs are not 64 bit clocks apart.

Top module: `ssi_burst_bridge`

## Requirements
- R1: While reset is asserted, and right after it, `sck_o` is 1, `hdat_o` is 0 and `frame_err_o` is 0. Reset also clears the held position word to 0.
- R2: A `fsync_i` high at a rising edge of `clk_i` starts a burst. With no further frame sync, `sck_o` then shows exactly 32 falling edges, the first at the next falling edge of `clk_i`. After that, `sck_o` stays at 1 until the next frame sync.
- R3: The block samples `sdat_i` at the rising edge of `clk_i` that ends each burst cycle. The first bit sampled is the most significant bit of the captured word.
- R4: A word completed in one burst appears on `hdat_o` in slots 0 to 31 of the next frame, most significant bit first. Slot k is driven from the rising edge that starts slot k (the frame-sync edge starts slot 0) until the next rising edge.
- R5: In slots 32 and later of a frame, and whenever no frame is running, `hdat_o` is 0.
- R6: A frame sync during a burst restarts the slot count. From the restart edge, 32 falling edges of `sck_o` follow. `sck_o` is never low while `clk_i` is high.
- R7: A burst cut short by a frame sync leaves the held word unchanged. A frame sync that lands on the edge that samples the 32nd bit still completes the capture, and slot 0 of the new frame carries that word's first bit.
- R8: At a frame sync that ends a running frame, `frame_err_o` is set if the spacing was other than 64 clocks and cleared if it was exactly 64. A frame sync arriving while idle leaves `frame_err_o` unchanged.
- R9: If 64 slots pass with no new frame sync, `frame_err_o` is set at that edge and the block goes idle. While idle there are no `sck_o` falling edges and `hdat_o` stays 0.
- R10: The burst enable that gates `sck_o` changes only while `clk_i` is high, so `sck_o` carries no runt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running host bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Host frame sync, sampled on rising edges |
| sdat_i | input | 1 | Serial data from the sensor |
| sck_o | output | 1 | Gated burst clock to the sensor, rests high |
| hdat_o | output | 1 | Serial data to the host, one bit per slot |
| frame_err_o | output | 1 | Level set when frame-sync spacing is not 64 |

## Verification
The hardest case to reach from the ports is a frame sync that lands in the same cycle as the sample of the 32nd bit. In that cycle the capture completes, the counter restarts and slot 0 reads the new word, all at once. A mid-burst restart is close behind: the sensor clock must keep toggling cleanly while the partial word is discarded. The stimulus table reaches both cases by placing frame syncs 32 and 20 clocks apart. A sensor model restarts its bit count on every frame sync, so the expected bits of each later frame can be traced back to the one word that should have survived. A long gap with no frame sync drives the late-sync path and the idle state.

// File: rtl/ssi_bb_pkg.sv
`timescale 1ns/1ps
package ssi_bb_pkg;

  // Kind of frame-sync event seen at a clock edge
  typedef enum logic [2:0] {
    SY_NONE,
    SY_FIRST,
    SY_GOOD,
    SY_EARLY,
    SY_LATE
  } sync_ev_e;

  // Next value of the frame-error level for a given event
  function automatic logic err_next(sync_ev_e ev, logic cur);
    logic nxt;
    unique case (ev)
      SY_GOOD:           nxt = 1'b0;
      SY_EARLY, SY_LATE: nxt = 1'b1;
      default:           nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/ssi_bb_frame_ctl.sv
`timescale 1ns/1ps
module ssi_bb_frame_ctl
  import ssi_bb_pkg::*;
#(
  parameter int BURST_LEN = 32,
  parameter int FRAME_LEN = 64,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             burst_o,
  output logic             done_o,
  output logic             err_o
);

  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BURST_LEN - 1);
  localparam logic [CNT_W:0]   BURST_W   = (CNT_W + 1)'(BURST_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             burst_q, burst_d;
  logic             err_q, err_d;
  sync_ev_e         ev;

  always_comb begin
    ev    = SY_NONE;
    cnt_d = cnt_q;
    run_d = run_q;
    if (fsync_i) begin
      cnt_d = '0;
      run_d = 1'b1;
      if (!run_q)                 ev = SY_FIRST;
      else if (cnt_q == LAST_SLOT) ev = SY_GOOD;
      else                        ev = SY_EARLY;
    end else if (run_q) begin
      if (cnt_q == LAST_SLOT) begin
        run_d = 1'b0;
        ev    = SY_LATE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    // Enable is a flop updated on the rising edge, i.e. while clk is high
    burst_d = run_d && ({1'b0, cnt_d} < BURST_W);
    err_d   = err_next(ev, err_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      burst_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      burst_q <= burst_d;
      err_q   <= err_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign run_o   = run_q;
  assign burst_o = burst_q;
  assign done_o  = burst_q && (cnt_q == LAST_BIT);
  assign err_o   = err_q;

endmodule

// File: rtl/ssi_bb_clk_gate.sv
`timescale 1ns/1ps
module ssi_bb_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);

  // en_i only moves while clk_i is high, so forcing high is safe
  assign gclk_o = clk_i | ~en_i;

endmodule

// File: rtl/ssi_bb_rx_capture.sv
`timescale 1ns/1ps
module ssi_bb_rx_capture #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              done_i,
  input  logic              sdat_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-2:0] sr_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      word_q <= '0;
    end else begin
      if (sample_i) sr_q <= {sr_q[WORD_W-3:0], sdat_i};
      if (done_i)   word_q <= {sr_q, sdat_i};
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/ssi_bb_slot_mux.sv
`timescale 1ns/1ps
module ssi_bb_slot_mux #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              burst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              hdat_o
);

  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] idx;

  always_comb begin
    idx    = TOP_IDX - cnt_i;
    hdat_o = 1'b0;
    if (burst_i) hdat_o = word_i[idx];
  end

endmodule

// File: rtl/ssi_burst_bridge.sv
`timescale 1ns/1ps
module ssi_burst_bridge #(
  parameter int BURST_LEN = 32,
  parameter int FRAME_LEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  input  logic sdat_i,
  output logic sck_o,
  output logic hdat_o,
  output logic frame_err_o
);

  localparam int CNT_W = $clog2(FRAME_LEN);

  logic [CNT_W-1:0]     cnt_q;
  logic                 run_q;
  logic                 burst_q;
  logic                 done;
  logic [BURST_LEN-1:0] word_q;

  ssi_bb_frame_ctl #(
    .BURST_LEN(BURST_LEN),
    .FRAME_LEN(FRAME_LEN)
  ) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .cnt_o   (cnt_q),
    .run_o   (run_q),
    .burst_o (burst_q),
    .done_o  (done),
    .err_o   (frame_err_o)
  );

  ssi_bb_clk_gate u_gate (
    .clk_i  (clk_i),
    .en_i   (burst_q),
    .gclk_o (sck_o)
  );

  ssi_bb_rx_capture #(
    .WORD_W(BURST_LEN)
  ) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (burst_q),
    .done_i   (done),
    .sdat_i   (sdat_i),
    .word_o   (word_q)
  );

  ssi_bb_slot_mux #(
    .WORD_W(BURST_LEN),
    .CNT_W (CNT_W)
  ) u_mux (
    .burst_i (burst_q),
    .cnt_i   (cnt_q),
    .word_i  (word_q),
    .hdat_o  (hdat_o)
  );

endmodule

// File: rtl/ssi_bb_checker.sv
`timescale 1ns/1ps
module ssi_bb_checker #(
  parameter int BURST_LEN = 32,
  parameter int FRAME_LEN = 64,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fsync_i,
  input logic                 hdat_o,
  input logic                 frame_err_o,
  input logic [CNT_W-1:0]     cnt,
  input logic                 run,
  input logic                 burst,
  input logic [BURST_LEN-1:0] word
);

  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BURST_LEN - 1);

  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni) fsync_i |=> (cnt == '0) && burst); // R6
  AST_BURST_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni) burst && (cnt == LAST_BIT) && !fsync_i |=> !burst); // R2
  AST_WORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) burst && (cnt != '0) |-> $stable(word)); // R4
  AST_PAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) !burst |-> !hdat_o); // R5
  AST_EARLY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni) fsync_i && run && (cnt != LAST_SLOT) |=> frame_err_o); // R8
  AST_GOOD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) fsync_i && run && (cnt == LAST_SLOT) |=> !frame_err_o); // R8
  AST_LATE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni) !fsync_i && run && (cnt == LAST_SLOT) |=> !run && frame_err_o); // R9

  always @(burst) begin
    if (rst_ni === 1'b1) begin
      AST_GATE_SAFE: assert (clk_i === 1'b1); // R10
    end
  end

endmodule

bind ssi_burst_bridge ssi_bb_checker #(
  .BURST_LEN(BURST_LEN),
  .FRAME_LEN(FRAME_LEN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fsync_i     (fsync_i),
  .hdat_o      (hdat_o),
  .frame_err_o (frame_err_o),
  .cnt         (cnt_q),
  .run         (run_q),
  .burst       (burst_q),
  .word        (word_q)
);

// File: tb/sim_ssi_burst_bridge.sv
`timescale 1ns/1ps
module sim_ssi_burst_bridge;

  localparam int BURST = 32;
  localparam int FRAME = 64;

  typedef struct packed {
    logic [31:0] pos;
    logic [7:0]  len;
    logic        err;
  } vec_t;

  // pos = sensor word, len = clocks until next frame sync, err = expected level in the frame
  localparam vec_t VECS [0:11] = '{
    '{32'hA5C3_0F1E, 8'd64, 1'b0},
    '{32'h1234_5678, 8'd64, 1'b0},
    '{32'hDEAD_BEEF, 8'd20, 1'b0},
    '{32'h8000_0001, 8'd64, 1'b1},
    '{32'h0F0F_F0F0, 8'd32, 1'b0},
    '{32'h7FFF_FFFE, 8'd64, 1'b1},
    '{32'hC001_D00D, 8'd70, 1'b0},
    '{32'h5555_AAAA, 8'd64, 1'b1},
    '{32'hFFFF_0000, 8'd64, 1'b0},
    '{32'h0000_FFFF, 8'd40, 1'b0},
    '{32'h3C3C_C3C3, 8'd64, 1'b1},
    '{32'h9ABC_DEF0, 8'd64, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic sdat = 1'b1;
  logic sck, hdat, ferr;

  always #5 clk = ~clk;

  ssi_burst_bridge u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fsync_i     (fsync),
    .sdat_i      (sdat),
    .sck_o       (sck),
    .hdat_o      (hdat),
    .frame_err_o (ferr)
  );

  int tests = 0;
  int fails = 0;
  int falls = 0;
  int sidx = 0;
  int glitch = 0;
  bit done = 1'b0;
  logic [31:0] sword = '0;
  logic [31:0] shown = '0;
  int prev_len = FRAME;

  // Sensor model: shifts one bit out after each falling edge, MSB first
  always @(negedge sck) begin
    if (sidx < BURST) sdat <= sword[BURST-1-sidx];
    else              sdat <= 1'b1;
    sidx  = sidx + 1;
    falls = falls + 1;
  end

  // R10: sensor clock must be high in the high phase of the bit clock
  always @(posedge clk) begin
    #2;
    if (rst_n === 1'b1 && sck !== 1'b1) glitch = glitch + 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] pos, input int len, input logic exp_err);
    logic rec [0:127];
    bit ok;
    int bad;
    int exp_falls;
    logic ebit;
    #1;
    sword = pos;
    sidx  = 0;
    falls = 0;
    fsync = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) fsync = 1'b0;
      rec[i] = hdat;
      if (i == 1) check(ferr == exp_err, "R8 err after sync", 64'(ferr), 64'(exp_err));
    end
    #1;
    ok  = 1'b1;
    bad = 0;
    for (int i = 0; i < len; i++) begin
      ebit = (i < BURST) ? shown[BURST-1-i] : 1'b0;
      if (ok && rec[i] !== ebit) begin
        ok  = 1'b0;
        bad = i;
      end
    end
    if (prev_len <= BURST)
      check(ok, "R7 R3 R4 R5 host slots", 64'(bad), 64'(shown));
    else
      check(ok, "R3 R4 R5 host slots", 64'(bad), 64'(shown));
    exp_falls = (len < BURST) ? len : BURST;
    if (prev_len < BURST)
      check(falls == exp_falls, "R6 falls after restart", 64'(falls), 64'(exp_falls));
    else
      check(falls == exp_falls, "R2 burst falls", 64'(falls), 64'(exp_falls));
    if (len > BURST) check(sck === 1'b1, "R2 sck idle high", 64'(sck), 64'd1);
    if (len > FRAME) check(ferr === 1'b1, "R9 late sync err", 64'(ferr), 64'd1);
    else             check(ferr === exp_err, "R8 err held", 64'(ferr), 64'(exp_err));
    if (len >= BURST) shown = pos;
    prev_len = len;
  endtask

  initial begin
    int zero_bad;
    #2;
    check(sck === 1'b1, "R1 reset sck", 64'(sck), 64'd1);
    check(hdat === 1'b0, "R1 reset hdat", 64'(hdat), 64'd0);
    check(ferr === 1'b0, "R1 reset err", 64'(ferr), 64'd0);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(falls == 0, "R9 no falls before sync", 64'(falls), 64'd0);

    for (int v = 0; v < 12; v++)
      run_frame(VECS[v].pos, int'(VECS[v].len), VECS[v].err);

    // Idle: no sync after the last frame, err goes high, no bursts
    #1;
    falls    = 0;
    zero_bad = 0;
    repeat (100) begin
      @(negedge clk);
      if (hdat !== 1'b0) zero_bad = zero_bad + 1;
    end
    #1;
    check(falls == 0, "R9 idle no falls", 64'(falls), 64'd0);
    check(zero_bad == 0, "R9 R5 idle hdat zero", 64'(zero_bad), 64'd0);
    check(ferr === 1'b1, "R9 missing sync err", 64'(ferr), 64'd1);
    check(sck === 1'b1, "R9 idle sck high", 64'(sck), 64'd1);

    // Reset in the middle of a burst
    #1;
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    repeat (10) @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check(sck === 1'b1, "R1 mid-burst reset sck", 64'(sck), 64'd1);
    check(hdat === 1'b0, "R1 mid-burst reset hdat", 64'(hdat), 64'd0);
    check(ferr === 1'b0, "R1 mid-burst reset err", 64'(ferr), 64'd0);
    @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    shown    = '0;
    prev_len = FRAME;
    run_frame(32'h2468_ACE0, FRAME, 1'b0);
    run_frame(32'h1357_9BDF, FRAME, 1'b0);

    check(glitch == 0, "R10 sck high while clk high", 64'(glitch), 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule